// File: doc/BRIEF.md
# In-Order Retirement Buffer with Physical Register Release

This block keeps the program order of instructions in flight in an out-of-order core. The dispatch stage writes up to `DISP_W` new entries per cycle at the tail of a circular store. Each entry records the architectural destination, the physical register that destination was mapped to before this instruction renamed it, and whether the instruction writes a register at all. Each granted dispatch slot receives the index of its entry as a tag. The function units return that tag on one of `CMP_W` completion ports when they finish. A completion marks its entry as done.

Retirement is strictly oldest-first and has no width limit. In a cycle, every entry in the unbroken run of done entries that starts at the head leaves the buffer. For each departing entry that has a destination, the old physical register is presented on a release lane so that a free list can reclaim it. Within a cycle, retirement comes first. It reads only completion marks that were recorded in earlier cycles, and the space it frees can be granted to dispatch in the same cycle. The occupancy is held in a separate count, and the block reports full and empty from it.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `ret_cnt`=0, and no release lane is valid.
- R2: Dispatch slot i is granted only if every slot below i also requests. The granted slot i receives tag (tail + i) mod DEPTH, where tail is the oldest free index.
- R3: Slot i is granted only if i < DEPTH − occupancy + ret_cnt. `full` is 1 exactly when occupancy equals DEPTH, and `empty` is 1 exactly when occupancy is 0.
- R4: A completion on port j with tag t marks entry t done at the clock edge. It cannot make that entry retire in the same cycle, only from the next cycle on.
- R5: If the head entry is not done, `ret_cnt` is 0, even when younger entries are done.
- R6: `ret_cnt` equals the length of the run of consecutive done entries that starts at the head, up to DEPTH, and all of them leave at the next edge.
- R7: For lane k < `ret_cnt` (lane 0 = head), `rel_vld[k]` equals the entry's has-destination flag. Lane k carries the previous physical register on `rel_preg[k*PREG_W +: PREG_W]` and the architectural register on `rel_areg[k*AREG_W +: AREG_W]`. An entry with no destination releases nothing, and lanes at or beyond `ret_cnt` are 0.
- R8: Head and tail wrap modulo DEPTH, so tags continue from DEPTH−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | DISP_W | Per-slot dispatch request, slot 0 oldest |
| alloc_has_dst | input | DISP_W | Slot writes an architectural register |
| alloc_areg | input | DISP_W*AREG_W | Architectural destination per slot |
| alloc_prev | input | DISP_W*PREG_W | Previous physical mapping per slot |
| alloc_grant | output | DISP_W | Slot accepted this cycle |
| alloc_tag | output | DISP_W*IDX_W | Entry index given to each slot |
| cmp_vld | input | CMP_W | Completion strobe per port |
| cmp_tag | input | CMP_W*IDX_W | Entry index being completed |
| ret_cnt | output | CNT_W | Entries leaving this cycle |
| rel_vld | output | DEPTH | Release lane carries a register to free |
| rel_areg | output | DEPTH*AREG_W | Architectural register per lane |
| rel_preg | output | DEPTH*PREG_W | Physical register to free per lane |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
A head pointer that is off by one shows up at once as a wrong `rel_preg` on lane 0 during the first retirement. A wrong occupancy count or tail shows up in the next dispatch cycle as a wrong grant or tag, or as a `full` flag in the wrong cycle. A lost or misplaced completion mark appears as a `ret_cnt` that stays 0 or counts too far in the cycle after the completion. The bench therefore checks each of these ports in the first cycle in which the fault would show.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // modular add for a ring of `depth` slots; b never exceeds depth
  function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                           int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

  // room available to dispatch once this cycle's retirements are counted
  function automatic int unsigned room_after_retire(int unsigned occ,
                                                    int unsigned nret,
                                                    int unsigned depth);
    return depth - occ + nret;
  endfunction
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int DISP_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DISP_W-1:0]         req,
  input  logic [IDX_W-1:0]          tail,
  input  logic [CNT_W-1:0]          room,
  output logic [DISP_W-1:0]         grant,
  output logic [DISP_W*IDX_W-1:0]   tag,
  output logic [CNT_W-1:0]          n_grant
);
  logic run;

  always_comb begin
    run     = 1'b1;
    n_grant = '0;
    for (int i = 0; i < DISP_W; i++) begin
      run = run & req[i] & (int'(room) > i);
      grant[i] = run;
      tag[i*IDX_W +: IDX_W] = IDX_W'(ring_add(int'(tail), i, DEPTH));
      n_grant = n_grant + CNT_W'(run);
    end
  end

  // R2
  grant_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0) && ((grant & (grant + 1'b1)) == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH  = 8,
  parameter int DISP_W = 2,
  parameter int CMP_W  = 2,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DISP_W-1:0]         wr_en,
  input  logic [DISP_W*IDX_W-1:0]   wr_tag,
  input  logic [DISP_W-1:0]         wr_dst,
  input  logic [DISP_W*AREG_W-1:0]  wr_areg,
  input  logic [DISP_W*PREG_W-1:0]  wr_prev,
  input  logic [CMP_W-1:0]          cmp_vld,
  input  logic [CMP_W*IDX_W-1:0]    cmp_tag,
  input  logic [DEPTH-1:0]          leave,
  input  logic [CNT_W-1:0]          occ,
  output logic [DEPTH-1:0]          done_vec,
  output logic [DEPTH-1:0]          dst_vec,
  output logic [DEPTH*AREG_W-1:0]   areg_vec,
  output logic [DEPTH*PREG_W-1:0]   prev_vec
);
  logic [DEPTH-1:0]  live_q, done_q, dst_q;
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [PREG_W-1:0] prev_q [DEPTH];

  // order inside the edge: retirement clears, completions mark, allocation resets
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      done_q <= '0;
      dst_q  <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        if (leave[e]) begin
          live_q[e] <= 1'b0;
          done_q[e] <= 1'b0;
        end
      for (int j = 0; j < CMP_W; j++)
        if (cmp_vld[j]) done_q[cmp_tag[j*IDX_W +: IDX_W]] <= 1'b1;
      for (int i = 0; i < DISP_W; i++)
        if (wr_en[i]) begin
          live_q[wr_tag[i*IDX_W +: IDX_W]] <= 1'b1;
          done_q[wr_tag[i*IDX_W +: IDX_W]] <= 1'b0;
          dst_q[wr_tag[i*IDX_W +: IDX_W]]  <= wr_dst[i];
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DISP_W; i++)
      if (wr_en[i]) begin
        areg_q[wr_tag[i*IDX_W +: IDX_W]] <= wr_areg[i*AREG_W +: AREG_W];
        prev_q[wr_tag[i*IDX_W +: IDX_W]] <= wr_prev[i*PREG_W +: PREG_W];
      end
  end

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      areg_vec[e*AREG_W +: AREG_W] = areg_q[e];
      prev_vec[e*PREG_W +: PREG_W] = prev_q[e];
    end
  end
  assign done_vec = done_q & live_q;
  assign dst_vec  = dst_q;

  // R3
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(live_q) == int'(occ));

  // R4
  generate
    for (genvar j = 0; j < CMP_W; j++) begin : g_cmp
      cmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_vld[j] |-> live_q[cmp_tag[j*IDX_W +: IDX_W]]
                       && !leave[cmp_tag[j*IDX_W +: IDX_W]]);
    end
  endgenerate
endmodule

// File: rtl/rob_scan.sv
module rob_scan import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          head,
  input  logic [CNT_W-1:0]          occ,
  input  logic [DEPTH-1:0]          done_vec,
  input  logic [DEPTH-1:0]          dst_vec,
  input  logic [DEPTH*AREG_W-1:0]   areg_vec,
  input  logic [DEPTH*PREG_W-1:0]   prev_vec,
  output logic [DEPTH-1:0]          leave,
  output logic [CNT_W-1:0]          n_ret,
  output logic [DEPTH-1:0]          rel_vld,
  output logic [DEPTH*AREG_W-1:0]   rel_areg,
  output logic [DEPTH*PREG_W-1:0]   rel_preg
);
  logic             run;
  logic [DEPTH-1:0] lane_on;
  int unsigned      idx;

  always_comb begin
    run      = 1'b1;
    n_ret    = '0;
    leave    = '0;
    lane_on  = '0;
    rel_vld  = '0;
    rel_areg = '0;
    rel_preg = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = ring_add(int'(head), k, DEPTH);
      run = run & (int'(occ) > k) & done_vec[idx];
      lane_on[k] = run;
      if (run) begin
        leave[idx] = 1'b1;
        rel_vld[k] = dst_vec[idx];
        rel_areg[k*AREG_W +: AREG_W] = areg_vec[idx*AREG_W +: AREG_W];
        rel_preg[k*PREG_W +: PREG_W] = prev_vec[idx*PREG_W +: PREG_W];
      end
      n_ret = n_ret + CNT_W'(run);
    end
  end

  // R5
  head_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_vec[head] |-> (n_ret == '0));

  // R7
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld & ~lane_on) == '0);

  // R6
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(n_ret) < int'(occ)) |->
      !done_vec[ring_add(int'(head), int'(n_ret), DEPTH)]);
endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int DISP_W = 2,
  parameter int CMP_W  = 2,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DISP_W-1:0]         alloc_vld,
  input  logic [DISP_W-1:0]         alloc_has_dst,
  input  logic [DISP_W*AREG_W-1:0]  alloc_areg,
  input  logic [DISP_W*PREG_W-1:0]  alloc_prev,
  output logic [DISP_W-1:0]         alloc_grant,
  output logic [DISP_W*IDX_W-1:0]   alloc_tag,
  input  logic [CMP_W-1:0]          cmp_vld,
  input  logic [CMP_W*IDX_W-1:0]    cmp_tag,
  output logic [CNT_W-1:0]          ret_cnt,
  output logic [DEPTH-1:0]          rel_vld,
  output logic [DEPTH*AREG_W-1:0]   rel_areg,
  output logic [DEPTH*PREG_W-1:0]   rel_preg,
  output logic                      full,
  output logic                      empty
);
  logic [IDX_W-1:0]        head_q, tail_q;
  logic [CNT_W-1:0]        occ_q, room, n_grant, n_ret;
  logic [DEPTH-1:0]        done_vec, dst_vec, leave;
  logic [DEPTH*AREG_W-1:0] areg_vec;
  logic [DEPTH*PREG_W-1:0] prev_vec;

  assign room = CNT_W'(room_after_retire(int'(occ_q), int'(n_ret), DEPTH));

  rob_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req(alloc_vld), .tail(tail_q), .room(room),
    .grant(alloc_grant), .tag(alloc_tag), .n_grant(n_grant));

  rob_store #(.DEPTH(DEPTH), .DISP_W(DISP_W), .CMP_W(CMP_W),
              .AREG_W(AREG_W), .PREG_W(PREG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(alloc_grant), .wr_tag(alloc_tag),
    .wr_dst(alloc_has_dst), .wr_areg(alloc_areg), .wr_prev(alloc_prev),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag), .leave(leave), .occ(occ_q),
    .done_vec(done_vec), .dst_vec(dst_vec), .areg_vec(areg_vec),
    .prev_vec(prev_vec));

  rob_scan #(.DEPTH(DEPTH), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .head(head_q), .occ(occ_q),
    .done_vec(done_vec), .dst_vec(dst_vec), .areg_vec(areg_vec),
    .prev_vec(prev_vec), .leave(leave), .n_ret(n_ret), .rel_vld(rel_vld),
    .rel_areg(rel_areg), .rel_preg(rel_preg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= IDX_W'(ring_add(int'(head_q), int'(n_ret), DEPTH));
      tail_q <= IDX_W'(ring_add(int'(tail_q), int'(n_grant), DEPTH));
      occ_q  <= occ_q - n_ret + n_grant;
    end
  end

  assign ret_cnt = n_ret;
  assign full    = (occ_q == CNT_W'(DEPTH));
  assign empty   = (occ_q == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) <= DEPTH);

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ret_cnt == '0) |-> (alloc_grant == '0));

  // R6
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (int'(occ_q) == int'($past(occ_q)) + int'($past(n_grant))
                        - int'($past(n_ret))));

  // R8
  ring_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) == ((int'(tail_q) - int'(head_q) + DEPTH) % DEPTH)
                   + (full ? DEPTH : 0));

  // R1
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/sim_inorder_retire_buf.sv
module sim_inorder_retire_buf;
  localparam int DEPTH = 8, DISP_W = 2, CMP_W = 2, AREG_W = 5, PREG_W = 6;
  localparam int IDX_W = 3, CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DISP_W-1:0]         alloc_vld = '0, alloc_has_dst = '0, alloc_grant;
  logic [DISP_W*AREG_W-1:0]  alloc_areg = '0;
  logic [DISP_W*PREG_W-1:0]  alloc_prev = '0;
  logic [DISP_W*IDX_W-1:0]   alloc_tag;
  logic [CMP_W-1:0]          cmp_vld = '0;
  logic [CMP_W*IDX_W-1:0]    cmp_tag = '0;
  logic [CNT_W-1:0]          ret_cnt;
  logic [DEPTH-1:0]          rel_vld;
  logic [DEPTH*AREG_W-1:0]   rel_areg;
  logic [DEPTH*PREG_W-1:0]   rel_preg;
  logic                      full, empty;

  int checks = 0, fails = 0, tail = 0, head = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  inorder_retire_buf #(.DEPTH(DEPTH), .DISP_W(DISP_W), .CMP_W(CMP_W),
    .AREG_W(AREG_W), .PREG_W(PREG_W)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic put(logic [1:0] v, logic [1:0] d, int a0, int p0, int a1, int p1);
    alloc_vld = v; alloc_has_dst = d;
    alloc_areg = {AREG_W'(a1), AREG_W'(a0)};
    alloc_prev = {PREG_W'(p1), PREG_W'(p0)};
  endtask

  task automatic fin(logic [1:0] v, int t0, int t1);
    cmp_vld = v; cmp_tag = {IDX_W'(t1), IDX_W'(t0)};
  endtask

  function automatic int lane_p(int k); return int'(rel_preg[k*PREG_W +: PREG_W]); endfunction
  function automatic int lane_a(int k); return int'(rel_areg[k*AREG_W +: AREG_W]); endfunction

  task automatic t_reset;
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 ret_cnt", int'(ret_cnt), 0);
    chk("R1 rel_vld", int'(rel_vld), 0);
  endtask

  task automatic t_order;
    put(2'b10, 2'b11, 3, 20, 4, 21); #1;
    chk("R2 gap grant", int'(alloc_grant), 0);
    put(2'b11, 2'b11, 3, 20, 4, 21); #1;
    chk("R2 grant", int'(alloc_grant), 3);
    chk("R2 tag0", int'(alloc_tag[2:0]), tail);
    chk("R2 tag1", int'(alloc_tag[5:3]), (tail + 1) % DEPTH);
    step; put(0, 0, 0, 0, 0, 0); #1;
    chk("R3 not empty", int'(empty), 0);
    fin(2'b01, (head + 1) % DEPTH, 0); #1;
    chk("R4 same-cycle", int'(ret_cnt), 0);
    step; fin(0, 0, 0); #1;
    chk("R5 younger done", int'(ret_cnt), 0);
    fin(2'b01, head, 0); step; fin(0, 0, 0); #1;
    chk("R6 ret two", int'(ret_cnt), 2);
    chk("R7 rel_vld", int'(rel_vld), 3);
    chk("R7 preg0", lane_p(0), 20);
    chk("R7 preg1", lane_p(1), 21);
    chk("R7 areg1", lane_a(1), 4);
    step; tail = (tail + 2) % DEPTH; head = tail;
    chk("R3 empty again", int'(empty), 1);
  endtask

  task automatic t_nodst;
    put(2'b11, 2'b01, 7, 30, 9, 31); step; put(0, 0, 0, 0, 0, 0);
    fin(2'b11, tail, (tail + 1) % DEPTH); step; fin(0, 0, 0); #1;
    chk("R7 nodst cnt", int'(ret_cnt), 2);
    chk("R7 nodst vld", int'(rel_vld), 1);
    chk("R7 nodst preg", lane_p(0), 30);
    step; tail = (tail + 2) % DEPTH; head = tail;
  endtask

  task automatic t_fill;
    int h;
    h = head;
    for (int n = 0; n < 4; n++) begin
      put(2'b11, 2'b11, n, 40 + 2*n, n + 8, 41 + 2*n); #1;
      chk("R8 wrap tag", int'(alloc_tag[5:3]), (tail + 1) % DEPTH);
      step; tail = (tail + 2) % DEPTH;
    end
    put(2'b11, 2'b11, 1, 50, 2, 51); #1;
    chk("R3 full flag", int'(full), 1);
    chk("R3 full stall", int'(alloc_grant), 0);
    put(0, 0, 0, 0, 0, 0);
    fin(2'b01, h, 0); step; fin(0, 0, 0);
    put(2'b11, 2'b11, 1, 50, 2, 51); #1;
    chk("R3 room from retire", int'(alloc_grant), 1);
    chk("R8 reuse tag", int'(alloc_tag[2:0]), h);
    step; put(0, 0, 0, 0, 0, 0); head = (h + 1) % DEPTH; #1;
    chk("R3 full again", int'(full), 1);
    for (int p = 7; p >= 1; p -= 2) begin
      fin(p == 1 ? 2'b01 : 2'b11, (head + p) % DEPTH, (head + p - 1) % DEPTH);
      step; fin(0, 0, 0); #1;
      chk("R5 held", int'(ret_cnt), 0);
    end
    fin(2'b01, head, 0); step; fin(0, 0, 0); #1;
    chk("R6 ret all", int'(ret_cnt), 8);
    chk("R7 all lanes", int'(rel_vld), 255);
    chk("R7 lane0 preg", lane_p(0), 41);
    chk("R7 lane7 preg", lane_p(7), 50);
    step;
    chk("R3 drained", int'(empty), 1);
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; #1;
    t_reset;
    t_order;
    t_nodst;
    t_fill;
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule